// File: doc/BRIEF.md
# Eight-Lane XOR Delta Block Encoder

This block compresses eight parallel streams of 64-bit samples. It takes one sample from each stream together as a group. Each sample is XORed with the previous sample of its own lane. The eight XOR results are packed into one variable-length data block, and the block leaves as a byte stream under a valid/ready handshake.

Compressed samples are rebuilt from lane history, so a stream normally opens with a reference group. The reference bytes pass through raw, with no header. A later group costs one byte when nothing changed. When lanes did change, a short bit-packed header follows the mask byte, and then only the significant window of bytes from each changed lane.

The input is held off while a block drains, so one group is processed at a time.

Top module: `xdelta_block_encoder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and every lane's history is zero. A compressed group of all-zero values sent first therefore yields the single byte 0xFF.
- R2: A group accepted with `in_ref` = 1 produces exactly 64 bytes and no header. The order is lane 0 first, and within a lane the least significant byte first. Each byte is the unmodified input. The group also becomes the lane history.
- R3: The first byte of a compressed block is the lane mask. Bit i is 1 exactly when lane i's new value equals its history.
- R4: When all eight lanes are unchanged, the block is the single byte 0xFF, flagged with `out_last`.
- R5: The mask is followed by one 3-bit offset field for each changed lane, in ascending lane order, packed LSB-first. Each field holds the count of whole zero bytes at the low end of that lane's XOR result.
- R6: A 3-bit length field follows the offsets. It holds L-1, where L is the largest significant length over the changed lanes. A lane's significant length is 8 minus its offset minus its count of zero bytes at the high end. The header is then zero-padded to a byte boundary.
- R7: After the header, each changed lane in ascending order contributes exactly L bytes. They start at that lane's offset byte and run least significant byte first. Positions past byte 7 are emitted as 0x00.
- R8: `in_ready` is low from the cycle after a group is accepted until the cycle after the block's last byte has been transferred. While `in_ready` is low, `in_valid` and `in_data` are ignored and leave the history unchanged.
- R9: `out_last` is 1 on the final byte of every block and on no other byte. The block is complete after that byte is transferred.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group offered |
| in_ref | input | 1 | 1: load the group as reference and emit it raw; 0: compress it |
| in_data | input | 512 | Group of eight 64-bit values, lane i in bits [64i+63:64i] |
| in_ready | output | 1 | Encoder can accept a group |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the current block |

## Verification
The bench sweeps all 256 patterns of which lanes change. Each changed lane gets a delta whose lowest and highest nonzero bytes move with the pattern, so every offset value and every shared length from 1 to 8 is reached. The all-unchanged pattern isolates the one-byte block. Patterns that mix a high-offset lane with a long lane show whether payload bytes past the top of a word come out as zeros. Reference loads recur through the sweep to prove that history is replaced. Random backpressure, together with junk offered on the input while a block drains, tells apart designs that hold the output stable and ignore the stalled input from those that do not.

// File: rtl/xde_pkg.sv
package xde_pkg;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_HDR  = 2'd1,
    SER_PAY  = 2'd2
  } ser_state_e;

  // Header bits before padding: mask + per-lane offsets + shared length
  function automatic int hdr_bits_max(input int lanes, input int ofs_w);
    return lanes + ofs_w * (lanes + 1);
  endfunction

endpackage

// File: rtl/xde_lane_scan.sv
module xde_lane_scan #(
  parameter  int WORD_BYTES = 8,
  localparam int OFS_W      = $clog2(WORD_BYTES),
  localparam int WORD_W     = WORD_BYTES * 8
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              is_zero_o,
  output logic [OFS_W-1:0]  tz_bytes_o,
  output logic [OFS_W:0]    sig_len_o
);

  logic [WORD_BYTES-1:0] byte_zero;

  genvar gb;
  generate
    for (gb = 0; gb < WORD_BYTES; gb++) begin : g_byte
      assign byte_zero[gb] = (word_i[gb*8 +: 8] == 8'h00);
    end
  endgenerate

  always_comb begin
    int  tz_cnt;
    int  lz_cnt;
    logic hit_lo;
    logic hit_hi;
    tz_cnt = 0;
    lz_cnt = 0;
    hit_lo = 1'b0;
    hit_hi = 1'b0;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (!hit_lo && byte_zero[b]) tz_cnt++;
      else                         hit_lo = 1'b1;
      if (!hit_hi && byte_zero[WORD_BYTES-1-b]) lz_cnt++;
      else                                      hit_hi = 1'b1;
    end
    is_zero_o  = &byte_zero;
    tz_bytes_o = is_zero_o ? '0 : OFS_W'(tz_cnt);
    sig_len_o  = is_zero_o ? '0 : (OFS_W+1)'(WORD_BYTES - tz_cnt - lz_cnt);
  end

endmodule

// File: rtl/xde_header_pack.sv
module xde_header_pack #(
  parameter  int LANES      = 8,
  parameter  int WORD_BYTES = 8,
  localparam int OFS_W      = $clog2(WORD_BYTES),
  localparam int HDR_BITS   = xde_pkg::hdr_bits_max(LANES, OFS_W),
  localparam int HDR_BYTES  = (HDR_BITS + 7) / 8,
  localparam int HDR_W      = HDR_BYTES * 8,
  localparam int HB_W       = $clog2(HDR_BYTES + 1)
) (
  input  logic [LANES-1:0]       mask_i,
  input  logic [LANES*OFS_W-1:0] ofs_i,
  input  logic [OFS_W-1:0]       len_code_i,
  output logic [HDR_W-1:0]       hdr_o,
  output logic [HB_W-1:0]        hdr_bytes_o
);

  always_comb begin
    int pos;
    hdr_o              = '0;
    hdr_o[LANES-1:0]   = mask_i;
    pos                = LANES;
    for (int l = 0; l < LANES; l++) begin
      if (!mask_i[l]) begin
        for (int k = 0; k < OFS_W; k++) hdr_o[pos+k] = ofs_i[l*OFS_W+k];
        pos += OFS_W;
      end
    end
    if (!(&mask_i)) begin
      for (int k = 0; k < OFS_W; k++) hdr_o[pos+k] = len_code_i[k];
      pos += OFS_W;
    end
    hdr_bytes_o = HB_W'((pos + 7) / 8);
  end

endmodule

// File: rtl/xde_serializer.sv
module xde_serializer #(
  parameter  int LANES      = 8,
  parameter  int WORD_BYTES = 8,
  parameter  int HDR_W      = 40,
  localparam int OFS_W      = $clog2(WORD_BYTES),
  localparam int WORD_W     = WORD_BYTES * 8,
  localparam int LW         = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int HB_W       = $clog2(HDR_W / 8 + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [LANES*WORD_W-1:0]   load_words_i,
  input  logic [LANES-1:0]          load_sel_i,
  input  logic [LANES*OFS_W-1:0]    load_ofs_i,
  input  logic [OFS_W:0]            load_len_i,
  input  logic [HDR_W-1:0]          load_hdr_i,
  input  logic [HB_W-1:0]           load_hdr_bytes_i,
  input  logic                      out_ready_i,
  output logic                      busy_o,
  output logic                      out_valid_o,
  output logic [7:0]                out_data_o,
  output logic                      out_last_o
);
  import xde_pkg::*;

  ser_state_e                state_q, state_d;
  logic [HB_W-1:0]           hidx_q, hidx_d;
  logic [LW-1:0]             lane_q, lane_d;
  logic [OFS_W-1:0]          bidx_q, bidx_d;

  logic [LANES*WORD_W-1:0]   words_q;
  logic [LANES-1:0]          sel_q;
  logic [LANES*OFS_W-1:0]    ofs_q;
  logic [OFS_W:0]            len_q;
  logic [HDR_W-1:0]          hdr_q;
  logic [HB_W-1:0]           hdr_bytes_q;
  logic                      capture;

  // {found, index} of the lowest selected lane at or above 'from'
  function automatic logic [LW:0] find_sel(input logic [LANES-1:0] sel, input int from);
    logic [LW:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (sel[i] && (i >= from)) r = {1'b1, LW'(i)};
    end
    return r;
  endfunction

  logic [LW:0]        nxt_sel, first_q_sel, first_ld_sel;
  logic [WORD_W-1:0]  lane_word;
  logic [OFS_W-1:0]   cur_ofs;
  logic [OFS_W:0]     src_byte;
  logic [7:0]         pay_byte, hdr_byte;
  logic               hdr_end, pay_end, fire;

  always_comb begin
    nxt_sel      = find_sel(sel_q, int'(lane_q) + 1);
    first_q_sel  = find_sel(sel_q, 0);
    first_ld_sel = find_sel(load_sel_i, 0);
    lane_word    = words_q[lane_q*WORD_W +: WORD_W];
    cur_ofs      = ofs_q[lane_q*OFS_W +: OFS_W];
    src_byte     = {1'b0, cur_ofs} + {1'b0, bidx_q};
    // shifting past the top of the word yields zero bytes
    pay_byte     = 8'(lane_word >> {src_byte, 3'b000});
    hdr_byte     = 8'(hdr_q >> {hidx_q, 3'b000});
    hdr_end      = (hidx_q == hdr_bytes_q - 1'b1);
    pay_end      = ({1'b0, bidx_q} == len_q - 1'b1);
  end

  assign busy_o      = (state_q != SER_IDLE);
  assign out_valid_o = busy_o;
  assign out_data_o  = (state_q == SER_HDR) ? hdr_byte : pay_byte;
  assign out_last_o  = (state_q == SER_HDR) ? (hdr_end && !first_q_sel[LW])
                                            : (pay_end && !nxt_sel[LW]);
  assign fire        = out_valid_o && out_ready_i;

  // next-state logic
  always_comb begin
    state_d = state_q;
    hidx_d  = hidx_q;
    lane_d  = lane_q;
    bidx_d  = bidx_q;
    capture = 1'b0;
    unique case (state_q)
      SER_IDLE: begin
        if (load_i) begin
          capture = 1'b1;
          state_d = (load_hdr_bytes_i != '0) ? SER_HDR : SER_PAY;
          hidx_d  = '0;
          bidx_d  = '0;
          lane_d  = first_ld_sel[LW-1:0];
        end
      end
      SER_HDR: begin
        if (fire) begin
          if (hdr_end) begin
            if (first_q_sel[LW]) begin
              state_d = SER_PAY;
              lane_d  = first_q_sel[LW-1:0];
              bidx_d  = '0;
            end else begin
              state_d = SER_IDLE;
            end
          end else begin
            hidx_d = hidx_q + 1'b1;
          end
        end
      end
      SER_PAY: begin
        if (fire) begin
          if (pay_end) begin
            if (nxt_sel[LW]) begin
              lane_d = nxt_sel[LW-1:0];
              bidx_d = '0;
            end else begin
              state_d = SER_IDLE;
            end
          end else begin
            bidx_d = bidx_q + 1'b1;
          end
        end
      end
      default: state_d = SER_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      hidx_q  <= '0;
      lane_q  <= '0;
      bidx_q  <= '0;
    end else begin
      state_q <= state_d;
      hidx_q  <= hidx_d;
      lane_q  <= lane_d;
      bidx_q  <= bidx_d;
    end
  end

  // block contents, enable-only
  always_ff @(posedge clk) begin
    if (capture) begin
      words_q     <= load_words_i;
      sel_q       <= load_sel_i;
      ofs_q       <= load_ofs_i;
      len_q       <= load_len_i;
      hdr_q       <= load_hdr_i;
      hdr_bytes_q <= load_hdr_bytes_i;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  // R7
  pay_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SER_PAY) |-> (len_q != '0) && (len_q <= (OFS_W+1)'(WORD_BYTES)));

  // R9
  last_ends_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_last_o |=> !out_valid_o);

endmodule

// File: rtl/xdelta_block_encoder.sv
module xdelta_block_encoder #(
  parameter  int LANES      = 8,
  parameter  int WORD_BYTES = 8,
  localparam int WORD_W     = WORD_BYTES * 8,
  localparam int DATA_W     = LANES * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_ref,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int OFS_W     = $clog2(WORD_BYTES);
  localparam int HDR_BITS  = xde_pkg::hdr_bits_max(LANES, OFS_W);
  localparam int HDR_BYTES = (HDR_BITS + 7) / 8;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int HB_W      = $clog2(HDR_BYTES + 1);

  logic [DATA_W-1:0]      hist_q, hist_d;
  logic [DATA_W-1:0]      xor_w;
  logic [LANES-1:0]       lane_zero;
  logic [LANES*OFS_W-1:0] lane_tz;
  logic [OFS_W:0]         lane_sig [LANES];
  logic [OFS_W:0]         max_len;
  logic [OFS_W-1:0]       len_code;
  logic [HDR_W-1:0]       hdr_w;
  logic [HB_W-1:0]        hdr_bytes_w;
  logic                   busy;
  logic                   acc;

  logic [DATA_W-1:0]      ld_words;
  logic [LANES-1:0]       ld_sel;
  logic [LANES*OFS_W-1:0] ld_ofs;
  logic [OFS_W:0]         ld_len;
  logic [HB_W-1:0]        ld_hdr_bytes;

  assign in_ready = !busy;
  assign acc      = in_valid && in_ready;
  assign xor_w    = in_data ^ hist_q;

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      xde_lane_scan #(.WORD_BYTES(WORD_BYTES)) u_scan (
        .word_i     (xor_w[gl*WORD_W +: WORD_W]),
        .is_zero_o  (lane_zero[gl]),
        .tz_bytes_o (lane_tz[gl*OFS_W +: OFS_W]),
        .sig_len_o  (lane_sig[gl])
      );
    end
  endgenerate

  always_comb begin
    max_len = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!lane_zero[l] && (lane_sig[l] > max_len)) max_len = lane_sig[l];
    end
    len_code = (max_len == '0) ? '0 : OFS_W'(max_len - 1'b1);
  end

  xde_header_pack #(.LANES(LANES), .WORD_BYTES(WORD_BYTES)) u_hdr (
    .mask_i      (lane_zero),
    .ofs_i       (lane_tz),
    .len_code_i  (len_code),
    .hdr_o       (hdr_w),
    .hdr_bytes_o (hdr_bytes_w)
  );

  always_comb begin
    if (in_ref) begin
      ld_words     = in_data;
      ld_sel       = '1;
      ld_ofs       = '0;
      ld_len       = (OFS_W+1)'(WORD_BYTES);
      ld_hdr_bytes = '0;
    end else begin
      ld_words     = xor_w;
      ld_sel       = ~lane_zero;
      ld_ofs       = lane_tz;
      ld_len       = max_len;
      ld_hdr_bytes = hdr_bytes_w;
    end
  end

  xde_serializer #(.LANES(LANES), .WORD_BYTES(WORD_BYTES), .HDR_W(HDR_W)) u_ser (
    .clk              (clk),
    .rst_n            (rst_n),
    .load_i           (acc),
    .load_words_i     (ld_words),
    .load_sel_i       (ld_sel),
    .load_ofs_i       (ld_ofs),
    .load_len_i       (ld_len),
    .load_hdr_i       (hdr_w),
    .load_hdr_bytes_i (ld_hdr_bytes),
    .out_ready_i      (out_ready),
    .busy_o           (busy),
    .out_valid_o      (out_valid),
    .out_data_o       (out_data),
    .out_last_o       (out_last)
  );

  // lane history: next-state and register
  always_comb begin
    hist_d = hist_q;
    if (acc) hist_d = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // R8
  busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R4
  all_same_one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_ref && (in_data == hist_q) |=> out_valid && out_last && (out_data == 8'hFF));

  // R2
  ref_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_ref |=> out_valid && !out_last && (out_data == $past(in_data[7:0])));

  // R3
  mask_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_ref |=> out_data[0] == ($past(in_data[WORD_W-1:0]) == $past(hist_q[WORD_W-1:0])));

endmodule

// File: tb/xdelta_block_encoder_tb_top.sv
`timescale 1ns/1ps
module xdelta_block_encoder_tb_top;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ref;
  logic [511:0] in_data;
  logic         in_ready;
  logic         out_valid;
  logic         out_ready;
  logic [7:0]   out_data;
  logic         out_last;

  xdelta_block_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ref(in_ref),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int          checks = 0;
  int          errors = 0;
  bit          summary_done = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [63:0] prev [8];
  logic [63:0] cur  [8];
  logic [7:0]  exp_b   [128];
  string       exp_req [128];
  int          exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Expected byte stream from the requirements
  task automatic build_expected(input bit is_ref, input string ovr);
    logic [63:0] delta [8];
    int          tz [8];
    logic [7:0]  mask;
    logic [63:0] hb;
    int          pos, len, nh;
    exp_n = 0;
    if (is_ref) begin
      for (int l = 0; l < 8; l++)
        for (int b = 0; b < 8; b++) begin
          exp_b[exp_n] = cur[l][8*b +: 8]; exp_req[exp_n] = "R2"; exp_n++;
        end
    end else begin
      hb = '0; len = 0; mask = '0;
      for (int l = 0; l < 8; l++) begin
        delta[l] = cur[l] ^ prev[l];
        mask[l]  = (delta[l] == 64'd0);
      end
      hb[7:0] = mask; pos = 8;
      for (int l = 0; l < 8; l++) begin
        if (!mask[l]) begin
          int lz, sig;
          tz[l] = 0; lz = 0;
          while (delta[l][8*tz[l] +: 8] == 8'h00) tz[l]++;
          while (delta[l][8*(7-lz) +: 8] == 8'h00) lz++;
          sig = 8 - tz[l] - lz;
          if (sig > len) len = sig;
          hb[pos +: 3] = 3'(tz[l]); pos += 3;
        end
      end
      if (mask != 8'hFF) begin hb[pos +: 3] = 3'(len - 1); pos += 3; end
      nh = (pos + 7) / 8;
      for (int b = 0; b < nh; b++) begin
        exp_b[exp_n] = hb[8*b +: 8]; exp_req[exp_n] = (b == 0) ? "R3" : "R5 R6"; exp_n++;
      end
      for (int l = 0; l < 8; l++) begin
        if (!mask[l])
          for (int j = 0; j < len; j++) begin
            int s;
            s = tz[l] + j;
            exp_b[exp_n] = (s < 8) ? delta[l][8*s +: 8] : 8'h00;
            exp_req[exp_n] = "R7"; exp_n++;
          end
      end
    end
    if (ovr != "") for (int k = 0; k < exp_n; k++) exp_req[k] = ovr;
    for (int l = 0; l < 8; l++) prev[l] = cur[l];
  endtask

  task automatic run_block(input bit is_ref, input string ovr);
    int         k;
    bit         done, stalled;
    logic [7:0] held_d;
    logic       held_l;
    build_expected(is_ref, ovr);
    @(negedge clk);
    in_valid = 1'b1;
    in_ref   = is_ref;
    for (int l = 0; l < 8; l++) in_data[l*64 +: 64] = cur[l];
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R8", "in_ready after accept", 64'(in_ready), 64'd0);
    k = 0; done = 0; stalled = 0;
    while (!done) begin
      if (stalled) begin
        chk(out_valid && out_data == held_d && out_last == held_l, "R10", "held byte",
            64'(out_data), 64'(held_d));
      end
      step_lfsr();
      out_ready = (lfsr[1:0] != 2'b00);
      // junk offered while busy must be ignored (R8)
      in_valid  = lfsr[5];
      in_ref    = lfsr[6];
      in_data   = {32{lfsr}};
      stalled   = 0;
      if (out_valid && out_ready) begin
        if (k >= exp_n) begin
          chk(0, "R9", "extra byte", 64'(k), 64'(exp_n));
          done = 1;
        end else begin
          chk(out_data == exp_b[k], exp_req[k], $sformatf("byte %0d", k), 64'(out_data), 64'(exp_b[k]));
          chk(out_last == (k == exp_n - 1), "R9", $sformatf("last at byte %0d", k),
              64'(out_last), 64'(k == exp_n - 1));
          k++;
          if (out_last) done = 1;
        end
        if (done) in_valid = 1'b0;
      end else if (out_valid) begin
        stalled = 1; held_d = out_data; held_l = out_last;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(k == exp_n, (exp_n == 1 && !is_ref) ? "R4" : "R9", "block length", 64'(k), 64'(exp_n));
    chk(in_ready && !out_valid, "R8", "ready after block", 64'({in_ready, out_valid}), 64'b10);
  endtask

  function automatic logic [63:0] pattern(input int m, input int l);
    logic [63:0] d;
    int o, t;
    o = (m + 3 * l) % 8;
    t = o + ((m * 5 + l) % (8 - o));
    d = '0;
    d[8*o +: 8] = 8'((m ^ (l << 4)) | 1);
    d[8*t +: 8] = d[8*t +: 8] | 8'(8'h80 | l | m);
    return d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!summary_done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary_done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_ref = 1'b0; in_data = '0; out_ready = 1'b0;
    for (int l = 0; l < 8; l++) prev[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

    // R1: zero history -> all-zero group is unchanged
    for (int l = 0; l < 8; l++) cur[l] = '0;
    run_block(0, "R1");

    // R2: reference load
    for (int l = 0; l < 8; l++) cur[l] = {8{8'(8'h11 * (l + 1))}} ^ 64'h0123_4567_89AB_CDEF;
    run_block(1, "");

    // R4: nothing changed
    run_block(0, "");

    // R7: high-offset lane beside a full-length lane
    cur[0] = prev[0] ^ 64'h8000_0000_0000_0000;
    cur[1] = prev[1] ^ 64'hFFFF_FFFF_FFFF_FFFF;
    cur[5] = prev[5] ^ 64'h0000_0100_0000_0000;
    run_block(0, "");

    // R3 R5 R6 R7: sweep every change pattern
    for (int m = 0; m < 256; m++) begin
      if (m % 32 == 31) begin
        for (int l = 0; l < 8; l++) cur[l] = {4{16'(m * 977 + l * 131)}};
        run_block(1, "");
      end
      for (int l = 0; l < 8; l++) cur[l] = m[l] ? (prev[l] ^ pattern(m, l)) : prev[l];
      run_block(0, "");
    end

    summary_done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule